// File: doc/BRIEF.md
# Searchable Hazard-Tracking Instruction Queue

This block is a shallow queue placed between an instruction decoder and an execute unit. The decoder pushes decoded instruction slots. Each slot holds a two-bit kind, a destination register name and two 32-bit operand values. The execute unit pops slots from the head. The decoder also asks the queue whether an older instruction still waiting in it will write a given register. It does this before pushing an instruction whose source registers could clash, and the answer comes back in the same cycle.

When a branch taken at the head redirects fetch, the execute unit raises a flush. All queued slots are then discarded. Within one cycle the operations resolve in a fixed order: the head is read first, then pop or flush takes effect, then the search is answered, and the push is applied last. Because of this order, producer and consumer can both act in every cycle.

The push side is a valid/ready stream. A slot is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever a slot will be free once this cycle's pop or flush has been applied, so a full queue still accepts a push in a cycle where it is popped. The pop side is also valid/ready. `out_valid` shows that a head slot is stored, and a pop happens when `out_ready` is high while `out_valid` is high. The head stays stable until it is popped or flushed. `flush`, the search name and the search result are plain pins.

Top module: `hzq_top`

## Requirements
- R1: After a synchronous active-high reset, no slot is stored: `out_valid` is 0, `q_empty` is 1, `q_full` is 0 and `srch_hit` is 0.
- R2: Slots leave in the order they were accepted. `out_valid` is 1 exactly when at least one slot is stored, and the head outputs show the oldest stored slot.
- R3: A cycle with `out_valid` and `out_ready` high, and `flush` low, removes exactly one slot: the head.
- R4: `q_full` is 1 when every one of the DEPTH slots is still live after this cycle's pop and flush, and `in_ready` is its inverse. A push is accepted when `in_valid` and `in_ready` are high, including into a full queue that is popped in the same cycle.
- R5: `srch_hit` is 1 when a live slot whose kind writes a register (add = 0, load = 2) has a destination equal to `srch_reg`.
- R6: A slot of kind branch-if-zero (1) or store (3) never causes a hit, whatever its destination field holds.
- R7: A slot popped in the current cycle is not searched.
- R8: When `flush` is high, every stored slot is discarded at the clock edge. In that same cycle `srch_hit` is 0 and `q_empty` is 1.
- R9: When `flush` and an accepted push fall in the same cycle, the queue afterwards holds only the pushed slot.
- R10: `q_empty` is 1 when no slot is live after this cycle's pop and flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Push request |
| in_ready | output | 1 | Queue can take a push this cycle |
| in_kind | input | 2 | Kind of pushed slot (0 add, 1 branch-if-zero, 2 load, 3 store) |
| in_dst | input | 5 | Destination register name of pushed slot |
| in_val_a | input | 32 | First operand value of pushed slot |
| in_val_b | input | 32 | Second operand value of pushed slot |
| out_valid | output | 1 | A head slot is stored |
| out_ready | input | 1 | Pop the head |
| out_kind | output | 2 | Head slot kind |
| out_dst | output | 5 | Head slot destination |
| out_val_a | output | 32 | Head slot first operand |
| out_val_b | output | 32 | Head slot second operand |
| flush | input | 1 | Discard every stored slot |
| srch_reg | input | 5 | Register name to search for |
| srch_hit | output | 1 | A live register-writing slot targets `srch_reg` |
| q_full | output | 1 | No slot free after this cycle's pop/flush |
| q_empty | output | 1 | No slot live after this cycle's pop/flush |

## Verification
The collisions of interest are a pop or flush landing in the same cycle as a search or a push. These show whether the ordering holds. The bench provokes them directly: it searches for the head's destination while popping it, pushes into a full queue while popping, and pushes while flushing. It then runs a long stretch of random traffic with a small register-name range, so that these coincidences recur often. Each cycle, a behavioural queue model computes the expected search result, fill flags and head. It applies the pop or flush before answering the search and the push afterwards, and every output is compared with this model before the clock edge.

// File: rtl/hzq_pkg.sv
package hzq_pkg;
  localparam int REG_W = 5;
  localparam int VAL_W = 32;

  typedef enum logic [1:0] {
    K_ADD = 2'd0,
    K_BZ  = 2'd1,
    K_LD  = 2'd2,
    K_ST  = 2'd3
  } kind_e;

  typedef struct packed {
    kind_e             kind;
    logic [REG_W-1:0]  dst;
    logic [VAL_W-1:0]  val_a;
    logic [VAL_W-1:0]  val_b;
  } slot_t;

  function automatic logic kind_writes(input kind_e k);
    return (k == K_ADD) || (k == K_LD);
  endfunction
endpackage

// File: rtl/hzq_store.sv
module hzq_store
  import hzq_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                enq,
  input  slot_t               enq_slot,
  input  logic                deq,
  input  logic                flush,
  output slot_t [DEPTH-1:0]   slots,
  output logic  [DEPTH-1:0]   held,
  output logic  [DEPTH-1:0]   live,
  output slot_t               head
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [PW-1:0]    rd_ptr, wr_ptr, wr_eff;
  logic [DEPTH-1:0] deq_mask, enq_mask, held_nxt;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_comb begin
    deq_mask = '0;
    enq_mask = '0;
    if (deq) deq_mask[rd_ptr] = 1'b1;
    live     = flush ? '0 : (held & ~deq_mask);
    wr_eff   = flush ? '0 : wr_ptr;
    if (enq) enq_mask[wr_eff] = 1'b1;
    held_nxt = live | enq_mask;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      held   <= '0;
      rd_ptr <= '0;
      wr_ptr <= '0;
    end else begin
      held   <= held_nxt;
      rd_ptr <= flush ? '0 : (deq ? bump(rd_ptr) : rd_ptr);
      wr_ptr <= enq ? bump(wr_eff) : wr_eff;
    end
  end

  always_ff @(posedge clk) begin
    if (enq) slots[wr_eff] <= enq_slot;
  end

  assign head = slots[rd_ptr];

  // R3: occupancy moves by exactly the push minus the pop when no flush
  assert_count_step_R3: assert property (@(posedge clk) disable iff (rst)
    !flush |=> ($countones(held) ==
                $countones($past(held)) + int'($past(enq)) - int'($past(deq))));

  // R9: flush together with a push leaves one slot
  assert_flush_push_single_R9: assert property (@(posedge clk) disable iff (rst)
    (flush && enq) |=> ($countones(held) == 1));

  // R8: flush alone leaves nothing stored
  assert_flush_drains_R8: assert property (@(posedge clk) disable iff (rst)
    (flush && !enq) |=> (held == '0));
endmodule

// File: rtl/hzq_match.sv
module hzq_match
  import hzq_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  slot_t [DEPTH-1:0]   slots,
  input  logic  [DEPTH-1:0]   live,
  input  logic  [REG_W-1:0]   srch_reg,
  output logic                hit
);
  logic [DEPTH-1:0] per_slot;

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign per_slot[i] = live[i] && kind_writes(slots[i].kind) &&
                         (slots[i].dst == srch_reg);
  end

  assign hit = |per_slot;
endmodule

// File: rtl/hzq_top.sv
module hzq_top
  import hzq_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [1:0]  in_kind,
  input  logic [4:0]  in_dst,
  input  logic [31:0] in_val_a,
  input  logic [31:0] in_val_b,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [1:0]  out_kind,
  output logic [4:0]  out_dst,
  output logic [31:0] out_val_a,
  output logic [31:0] out_val_b,
  input  logic        flush,
  input  logic [4:0]  srch_reg,
  output logic        srch_hit,
  output logic        q_full,
  output logic        q_empty
);
  slot_t [DEPTH-1:0] slots;
  logic  [DEPTH-1:0] held, live;
  slot_t             head, enq_slot;
  logic              enq, deq;

  assign enq_slot = '{kind: kind_e'(in_kind), dst: in_dst, val_a: in_val_a, val_b: in_val_b};
  assign out_valid = |held;
  assign deq       = out_valid && out_ready;
  assign q_full    = &live;
  assign q_empty   = ~|live;
  assign in_ready  = !q_full;
  assign enq       = in_valid && in_ready;

  assign out_kind  = head.kind;
  assign out_dst   = head.dst;
  assign out_val_a = head.val_a;
  assign out_val_b = head.val_b;

  hzq_store #(.DEPTH(DEPTH)) store_i (
    .clk(clk), .rst(rst), .enq(enq), .enq_slot(enq_slot), .deq(deq),
    .flush(flush), .slots(slots), .held(held), .live(live), .head(head)
  );

  hzq_match #(.DEPTH(DEPTH)) match_i (
    .slots(slots), .live(live), .srch_reg(srch_reg), .hit(srch_hit)
  );

  // R2: an unpopped head stays put
  assert_head_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready && !flush) |=> (out_valid && $stable(head)));

  // R5: a hit needs a live slot
  assert_hit_needs_live_R5: assert property (@(posedge clk) disable iff (rst)
    srch_hit |-> !q_empty);

  // R8: a flushing cycle sees an empty queue
  assert_flush_no_hit_R8: assert property (@(posedge clk) disable iff (rst)
    flush |-> (!srch_hit && q_empty && in_ready));

  // R1: nothing stored right after reset
  assert_reset_clean_R1: assert property (@(posedge clk)
    $past(rst) |-> !out_valid);
endmodule

// File: tb/hzq_top_tb_top.sv
module hzq_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 3;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid, in_ready, out_valid, out_ready, flush;
  logic [1:0]  in_kind, out_kind;
  logic [4:0]  in_dst, out_dst, srch_reg;
  logic [31:0] in_val_a, in_val_b, out_val_a, out_val_b;
  logic        srch_hit, q_full, q_empty;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit prev_deq = 1'b0;
  bit prev_fe = 1'b0;
  logic [70:0] mq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  hzq_top #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_kind(in_kind), .in_dst(in_dst), .in_val_a(in_val_a), .in_val_b(in_val_b),
    .out_valid(out_valid), .out_ready(out_ready), .out_kind(out_kind),
    .out_dst(out_dst), .out_val_a(out_val_a), .out_val_b(out_val_b),
    .flush(flush), .srch_reg(srch_reg), .srch_hit(srch_hit),
    .q_full(q_full), .q_empty(q_empty)
  );

  task automatic chk(input string tag, input string what,
                     input logic [70:0] got, input logic [70:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s got=%h exp=%h t=%0t", tag, what, got, exp, $time);
    end
  endtask

  task automatic do_cycle(input logic iv, input logic [1:0] k, input logic [4:0] d,
                          input logic [31:0] a, input logic [31:0] b,
                          input logic ordy, input logic fl, input logic [4:0] sr);
    bit e_valid, e_deq, e_full, e_empty, e_hit, e_enq, odd_match;
    int live_n;
    string htag;
    @(negedge clk);
    in_valid = iv; in_kind = k; in_dst = d; in_val_a = a; in_val_b = b;
    out_ready = ordy; flush = fl; srch_reg = sr;
    #1;
    e_valid = (mq.size() > 0);
    e_deq   = e_valid && ordy;
    live_n  = fl ? 0 : (mq.size() - (e_deq ? 1 : 0));
    e_full  = (live_n == DEPTH);
    e_empty = (live_n == 0);
    e_hit = 1'b0;
    odd_match = 1'b0;
    if (!fl) begin
      for (int i = (e_deq ? 1 : 0); i < mq.size(); i++) begin
        if (mq[i][68:64] == sr) begin
          if (mq[i][70:69] == 2'd0 || mq[i][70:69] == 2'd2) e_hit = 1'b1;
          else odd_match = 1'b1;
        end
      end
    end
    chk("R2", "out_valid", 71'(out_valid), 71'(e_valid));
    if (e_valid) begin
      htag = prev_fe ? "R9" : (prev_deq ? "R3" : "R2");
      chk(htag, "head", {out_kind, out_dst, out_val_a, out_val_b}, mq[0]);
    end
    chk("R4", "q_full", 71'(q_full), 71'(e_full));
    chk("R4", "in_ready", 71'(in_ready), 71'(!e_full));
    chk(fl ? "R8" : "R10", "q_empty", 71'(q_empty), 71'(e_empty));
    htag = fl ? "R8" : (e_deq && mq.size() > 0 && mq[0][68:64] == sr) ? "R7"
         : (odd_match ? "R6" : "R5");
    chk(htag, "srch_hit", 71'(srch_hit), 71'(e_hit));
    e_enq = iv && !e_full;
    if (fl) mq.delete();
    else if (e_deq) void'(mq.pop_front());
    if (e_enq) mq.push_back({k, d, a, b});
    prev_deq = e_deq && !fl;
    prev_fe  = fl && e_enq;
  endtask

  task automatic idle(input logic [4:0] sr);
    do_cycle(1'b0, 2'd0, 5'd0, 32'd0, 32'd0, 1'b0, 1'b0, sr);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; in_valid = 0; in_kind = 0; in_dst = 0; in_val_a = 0; in_val_b = 0;
    out_ready = 0; flush = 0; srch_reg = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R1: reset state
    #1;
    chk("R1", "out_valid", 71'(out_valid), 71'(0));
    chk("R1", "q_empty", 71'(q_empty), 71'(1));
    chk("R1", "q_full", 71'(q_full), 71'(0));
    chk("R1", "srch_hit", 71'(srch_hit), 71'(0));
    // fill: add r5, load r6, branch r7 (R5, R6, R4)
    do_cycle(1, 2'd0, 5'd5, 32'h11, 32'h12, 0, 0, 5'd5);
    do_cycle(1, 2'd2, 5'd6, 32'h21, 32'h22, 0, 0, 5'd5);
    do_cycle(1, 2'd1, 5'd7, 32'h31, 32'h32, 0, 0, 5'd6);
    idle(5'd7);  // R6: branch dst never hits
    do_cycle(1, 2'd3, 5'd9, 32'h41, 32'h42, 0, 0, 5'd9); // full, refused (R4)
    // R4/R7: push into full queue while popping; search popped head
    do_cycle(1, 2'd3, 5'd9, 32'h51, 32'h52, 1, 0, 5'd5);
    idle(5'd9);  // R6: store dst never hits
    do_cycle(0, 2'd0, 5'd0, 32'd0, 32'd0, 1, 0, 5'd6); // R7
    // R9: flush with push
    do_cycle(1, 2'd2, 5'd3, 32'h61, 32'h62, 0, 1, 5'd3);
    idle(5'd3);
    // R8: flush alone with search
    do_cycle(0, 2'd0, 5'd0, 32'd0, 32'd0, 0, 1, 5'd3);
    idle(5'd3);
    // random traffic
    for (int n = 0; n < 4000; n++) begin
      do_cycle(($urandom % 4) != 0, 2'($urandom % 4), 5'($urandom % 4),
               $urandom, $urandom, 1'($urandom % 2), ($urandom % 16) == 0,
               5'($urandom % 4));
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule